// File: doc/BRIEF.md
# Clock Generator Configuration Slave (I2C)

This block is the serial configuration front end of a multi-output clock generator. An external I2C master programs a small bank of byte-wide control registers, and the block drives their contents as plain levels towards the clock-enable and frequency-select logic. SCL and SDA arrive as raw pad inputs. The block brings them into the system clock domain, detects START and STOP, and runs a byte-level slave state machine. SDA is driven open-drain style: asserting `sda_oe` pulls the line low.

A write carries no register address. After its own address with the write bit, the master sends two bytes (a command code and a byte count). The slave acknowledges both and discards them. Every data byte after that lands in the next register, starting at register 0. A read starts at register 0 and returns consecutive registers. The read wraps after the last one and two of the registers are fixed identification bytes. Register contents are set to their defaults only by the power-on reset. No bus event reloads them.

There is no valid/ready stream at this block's edge. The I2C bus already paces the data by its own acknowledge and clock, and the register outputs are static control levels with no handshake.

Top module: `clkgen_cfg_i2c`

## Requirements
- R1: A byte following START whose upper seven bits equal the parameter `SLV_ADDR` is acknowledged (SDA pulled low on the ninth clock). Any other address is not acknowledged, and SDA stays released until the next START.
- R2: In a write transfer, the two bytes after the address (command code, byte count) are acknowledged and never stored, whatever their values.
- R3: Data bytes after the command and count bytes are written in order to register 0, 1, 2, and so on. A transfer of fewer bytes leaves the later registers unchanged.
- R4: Power-on reset loads register 0 with 0x47, registers 1 and 2 with 0xFF, register 3 with 0x6E, and registers 4 and 5 with 0x00. `sda_oe` is low during and after reset.
- R5: Register 6 always reads 0x92 and register 7 always reads 0x01. Data bytes aimed at them are acknowledged and have no effect.
- R6: Data bytes beyond register 7 are acknowledged and discarded, and registers 0 to 5 keep the first six data bytes.
- R7: A read (address byte with LSB 1) returns register 0 first, then registers in ascending order, wrapping from register 7 back to register 0. A master NACK ends the read, and SDA stays released afterwards.
- R8: A START, including a repeated START in the middle of a transfer, restarts the byte sequence, so the next write data byte goes to register 0 again. Register values persist across transfers.
- R9: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous to the bus |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_q | output | NRW*8 | Writable registers 0..NRW-1, register n in bits [8n+7:8n] |

## Verification
The embedded properties assume a well-formed master. SDA changes only while SCL is low, except at START and STOP. Every SCL phase lasts several system clocks longer than the two-flop synchronizer latency. The master never issues START or STOP while the slave holds SDA low. The bench master holds each quarter bit period for twelve system clocks and moves SDA only in the middle of the SCL low phase, so the synchronized SCL edge always precedes the synchronized SDA change. The master releases SDA before every acknowledge and read bit, so the wired line shows only the slave's drive there.

// File: rtl/ckcfg_pkg.sv
`timescale 1ns/100ps
package ckcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } slv_state_e;

  // Power-up contents; indices 6 and 7 are the fixed identification bytes.
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h47;
      1, 2:    return 8'hFF;
      3:       return 8'h6E;
      6:       return 8'h92;
      7:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/100ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_o  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_i2c_fsm.sv
`timescale 1ns/100ps
module cfg_i2c_fsm
  import ckcfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         NREG     = 8,
  parameter int         NRW      = 6,
  localparam int        IW       = $clog2(NREG),
  localparam int        PW       = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start,
  input  logic          stop,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data
);
  localparam logic [PW-1:0] PTR_END  = PW'(NREG);
  localparam logic [PW-1:0] PTR_LAST = PW'(NREG - 1);
  localparam logic [PW-1:0] PTR_RW   = PW'(NRW);

  slv_state_e    state;
  logic [3:0]    bitcnt;
  logic [1:0]    byte_idx;   // 0 address, 1 command, 2 count, 3 data
  logic [PW-1:0] ptr;
  logic [7:0]    rx_sh, tx_sh;
  logic          is_read, mack_ok;

  assign rd_idx = ptr[IW-1:0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      byte_idx <= '0;
      ptr      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_read  <= 1'b0;
      mack_ok  <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start) begin
        state    <= ST_RX;
        bitcnt   <= '0;
        byte_idx <= '0;
        ptr      <= '0;
        sda_oe   <= 1'b0;
      end else if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (byte_idx == 2'd0) begin
                if (rx_sh[7:1] == SLV_ADDR) begin
                  is_read <= rx_sh[0];
                  state   <= ST_ACK;
                  sda_oe  <= 1'b1;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                state  <= ST_ACK;
                sda_oe <= 1'b1;
                if (byte_idx == 2'd3) begin
                  if (ptr < PTR_RW) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr[IW-1:0];
                    wr_data <= rx_sh;
                  end
                  if (ptr != PTR_END) ptr <= ptr + 1'b1;
                end
              end
              if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                state  <= ST_TX;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
              if (!sda_s) ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
            end else if (scl_fall) begin
              if (mack_ok) begin
                state  <= ST_TX;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: after a NACKed address or master NACK the line stays released
  p_wait_released_r1: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_WAIT) |-> !sda_oe);

  // R3: each stored byte advances the write pointer by exactly one
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |-> (ptr == PW'(wr_idx) + 1'b1));

  // R8: a START from the line detector restarts the sequence at register 0
  p_start_restart_r8: assert property (@(posedge clk) disable iff (!por_n)
    start |=> (state == ST_RX && bitcnt == 4'd0 && ptr == '0 && byte_idx == 2'd0));

endmodule

// File: rtl/cfg_regbank.sv
`timescale 1ns/100ps
module cfg_regbank
  import ckcfg_pkg::*;
#(
  parameter int  NREG = 8,
  parameter int  NRW  = 6,
  localparam int IW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [7:0]     wr_data,
  input  logic [IW-1:0]  rd_idx,
  output logic [7:0]     rd_data,
  output logic [NRW*8-1:0] regs_o
);
  logic [7:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < NRW) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                             q <= reg_default(g);
        else if (wr_en && wr_idx == IW'(g))     q <= wr_data;
      end
      assign bank[g]         = q;
      assign regs_o[g*8 +: 8] = q;
    end else begin : g_ro
      assign bank[g] = reg_default(g);
    end
  end

  assign rd_data = bank[rd_idx];

  // R5: the engine never aims a store at an identification register
  p_wr_range_r5: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |-> (wr_idx < IW'(NRW)));

  // R8: registers hold their values between stores
  p_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(regs_o));

endmodule

// File: rtl/clkgen_cfg_i2c.sv
`timescale 1ns/100ps
module clkgen_cfg_i2c #(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         NREG     = 8,
  parameter int         NRW      = 6,
  parameter int         STAGES   = 2,
  localparam int        IW       = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [NRW*8-1:0] cfg_q
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data;

  i2c_line_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  cfg_i2c_fsm #(.SLV_ADDR(SLV_ADDR), .NREG(NREG), .NRW(NRW)) u_fsm (
    .clk(clk), .por_n(por_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start(start), .stop(stop), .rd_data(rd_data),
    .rd_idx(rd_idx), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data)
  );

  cfg_regbank #(.NREG(NREG), .NRW(NRW)) u_bank (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(cfg_q)
  );

  // R9: the SDA driver only moves while synchronized SCL was low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(sda_oe) |-> !$past(scl_s));

endmodule

// File: tb/clkgen_cfg_i2c_tb.sv
`timescale 1ns/100ps
module clkgen_cfg_i2c_tb;
  localparam logic [6:0] ADDR = 7'h69;
  localparam real Q = 60.0;
  localparam logic [47:0] VEC [4] = '{
    48'h0123456789AB, 48'hFEDCBA987654, 48'h00FF00FF00FF, 48'hA55A3CC31248
  };

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] cfg_q;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, oe_bad = 0;
  logic [7:0] exp_r [8];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #2.5 clk = ~clk;

  clkgen_cfg_i2c #(.SLV_ADDR(ADDR)) u_dut (
    .clk(clk), .por_n(por_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  // R9 monitor: any slave drive change while the SCL pin is high
  always @(sda_oe) if (por_n === 1'b1 && scl_m === 1'b1) oe_bad++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [47:0] exp_bus();
    return {exp_r[5], exp_r[4], exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic put_bit(input bit b, output bit line);
    sda_m = b; #Q; scl_m = 1'b1; #Q; line = sda_line; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit d;
    for (int i = 7; i >= 0; i--) put_bit(b[i], d);
    put_bit(1'b1, d);
    ack = !d;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    bit d;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      put_bit(1'b1, d);
      b = {b[6:0], d};
    end
    put_bit(nack, d);
  endtask

  // address, command, count, then n data bytes from wbuf; counts ACKs seen
  task automatic wr_burst(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] cnt,
                          input int n, input bit stop_at_end, output int acks);
    bit ak;
    acks = 0;
    bus_start();
    send_byte({a, 1'b0}, ak); acks += int'(ak);
    send_byte(cmd, ak);       acks += int'(ak);
    send_byte(cnt, ak);       acks += int'(ak);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); acks += int'(ak);
    end
    if (stop_at_end) bus_stop();
    if (a == ADDR)
      for (int i = 0; i < n && i < 6; i++) exp_r[i] = wbuf[i];
  endtask

  task automatic rd_burst(input int n, output bit addr_ack);
    bus_start();
    send_byte({ADDR, 1'b1}, addr_ack);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i == n - 1);
  endtask

  initial begin
    #950000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int acks;
    bit ak;
    for (int i = 0; i < 8; i++) exp_r[i] = 8'h00;
    exp_r[0] = 8'h47; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF; exp_r[3] = 8'h6E;
    exp_r[6] = 8'h92; exp_r[7] = 8'h01;

    #101.3;
    chk(sda_oe == 1'b0, "R4 oe in reset", 64'(sda_oe), 64'h0);
    chk(cfg_q == exp_bus(), "R4 defaults in reset", 64'(cfg_q), 64'(exp_bus()));
    por_n = 1'b1;
    #(4*Q);
    chk(cfg_q == exp_bus(), "R4 defaults after reset", 64'(cfg_q), 64'(exp_bus()));

    // R4 R5: read-back of power-up contents and identification bytes
    rd_burst(8, ak); bus_stop();
    chk(ak, "R1 read address ack", 64'(ak), 64'h1);
    for (int i = 0; i < 8; i++)
      chk(rbuf[i] == exp_r[i], (i >= 6) ? "R5 id read" : "R4 default read",
          64'(rbuf[i]), 64'(exp_r[i]));

    // Vector table: full write then full read-back (R3, R7, R5)
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < 6; i++) wbuf[i] = VEC[v][8*i +: 8];
      wr_burst(ADDR, 8'h00, 8'h06, 6, 1'b1, acks);
      chk(acks == 9, "R2 all bytes acked", 64'(acks), 64'd9);
      chk(cfg_q == exp_bus(), "R3 ordered store", 64'(cfg_q), 64'(exp_bus()));
      rd_burst(8, ak); bus_stop();
      for (int i = 0; i < 8; i++)
        chk(rbuf[i] == exp_r[i], (i >= 6) ? "R5 id after write" : "R7 ascending read",
            64'(rbuf[i]), 64'(exp_r[i]));
    end

    // R1: foreign address, no ACK, nothing stored
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hC0 + 8'(i);
    wr_burst(ADDR ^ 7'h01, 8'h00, 8'h06, 6, 1'b1, acks);
    chk(acks == 0, "R1 foreign address not acked", 64'(acks), 64'd0);
    chk(cfg_q == exp_bus(), "R1 foreign address no store", 64'(cfg_q), 64'(exp_bus()));

    // R2 R3: command/count look like data but are dropped; short write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_burst(ADDR, 8'h3C, 8'h02, 2, 1'b1, acks);
    chk(acks == 5, "R2 command and count acked", 64'(acks), 64'd5);
    chk(cfg_q[7:0] == 8'h11, "R2 command byte not stored", 64'(cfg_q[7:0]), 64'h11);
    chk(cfg_q == exp_bus(), "R3 short write leaves rest", 64'(cfg_q), 64'(exp_bus()));

    // R6 R5: eleven data bytes; extras acked, ids untouched
    for (int i = 0; i < 11; i++) wbuf[i] = 8'h30 + 8'(i);
    wr_burst(ADDR, 8'hFF, 8'hFF, 11, 1'b1, acks);
    chk(acks == 14, "R6 excess bytes acked", 64'(acks), 64'd14);
    chk(cfg_q == exp_bus(), "R6 first six kept", 64'(cfg_q), 64'(exp_bus()));

    // R7: wrap after register 7, then NACK ends read
    rd_burst(10, ak);
    for (int i = 0; i < 10; i++)
      chk(rbuf[i] == exp_r[i % 8], (i >= 8) ? "R7 wrap to register 0" : "R5 R7 read",
          64'(rbuf[i]), 64'(exp_r[i % 8]));
    begin
      bit d;
      int lows = 0;
      for (int i = 0; i < 9; i++) begin
        put_bit(1'b1, d);
        if (!d) lows++;
      end
      chk(lows == 0 && sda_oe == 1'b0, "R7 released after NACK", 64'(lows), 64'd0);
    end
    bus_stop();

    // R8: repeated START mid-write sends next data back to register 0
    wbuf[0] = 8'hA5;
    wr_burst(ADDR, 8'h00, 8'h01, 1, 1'b0, acks);
    wbuf[0] = 8'h5A;
    wr_burst(ADDR, 8'h00, 8'h01, 1, 1'b1, acks);
    chk(cfg_q[7:0] == 8'h5A, "R8 repeated start restarts at reg0", 64'(cfg_q[7:0]), 64'h5A);
    chk(cfg_q == exp_bus(), "R8 other registers persist", 64'(cfg_q), 64'(exp_bus()));

    chk(oe_bad == 0, "R9 drive changes only with SCL low", 64'(oe_bad), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule